// File: doc/BRIEF.md
# Two-Channel Countdown Timer with Identification Window

This block places two identical down-counting timer channels behind a single 4 KB register window. A write strobe, a byte address and write data arrive from an upstream bus adapter. Read data is a combinational function of the address. The window sends each access to channel 0 or channel 1, or to a small read-only table of identification bytes near its top. Every other location reads as zero and ignores writes.

Each channel counts down on ticks of its own tick-enable input, so the two channels can run from unrelated base rates. A channel can run in free-running, periodic or one-shot fashion, and a prescaler can divide its tick rate by 1, 16 or 256. The masked interrupts of the two channels are ORed onto one interrupt line.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, each channel's control word (word index 2) reads 0x20, meaning interrupt enable set and the counter stopped. Load, value and raw status read 0, and irq is low.
- R2: Byte offsets 0x00–0x1F reach channel 0 and offsets 0x20–0x3F reach channel 1. Within a channel, the word index is offset bits 4:2: 0 load, 1 value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load, and 7 reads 0.
- R3: A load write stores the limit and sets the count to the reload value of the current mode. A background-load write stores only the limit. Both writes are visible at word 0.
- R4: While control bit 7 (run) is set, the count falls by one on each prescaled tick of that channel's own tickEn bit. Without a tick, the count holds.
- R5: Control bits 3:2 set the prescale. With 00 every tick counts, with 01 every 16th tick counts, with 10 every 256th tick counts, and 11 behaves as 00. A control write restarts the prescale phase.
- R6: The reload value is the limit when control bit 6 (periodic) or bit 0 (one-shot) is set. Otherwise the mode is free-running and the reload value is 0xFFFFFFFF if bit 1 (wide) is set, else 0xFFFF. In the wrapping modes, a counted tick at zero loads the reload value.
- R7: In one-shot mode, a count of zero stays at zero on further ticks.
- R8: A counted step from 1 to 0 sets the raw status, which reads as bit 0 of word 4. Word 5 reads raw status AND control bit 5 (interrupt enable). Any write to word 3 clears the raw status, but a step to zero in the same cycle wins.
- R9: irq is the OR of the two channels' masked statuses.
- R10: Offsets 0xFE0–0xFFC read, one byte per word in bits 7:0 with the upper bits zero, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Offsets 0xF00 and 0xF04, channel word 7, word 3 and every unlisted offset read 0. A write to the value word has no effect.
- R12: Writes at offsets 0x40 and above change no channel state, including writes to the identification and test offsets.
- R13: A control write with the run bit set reloads the count with the reload value of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 2 | Per-channel count enable, bit n for channel n |
| wrEn | input | 1 | Write strobe |
| addr | input | 12 | Byte offset in the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Merged interrupt |

## Verification
A wrong window decode shows on the same cycle as a wrong read value, or as the other channel's registers changing on the next read. A wrong prescale or reload state shows only on the first counted tick after the fault, so the checks read the value word right after each tick burst and right at the 16th and 256th tick. A fault in the status latch shows on irq one cycle after the step to zero or after the clear write. The bench provokes the same-cycle clear-versus-set race on purpose.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int WIN_AW = 12;
  localparam int NUM_CH = 2;

  // control bit positions (software decodes these)
  localparam int CB_ONESHOT = 0;
  localparam int CB_WIDE    = 1;
  localparam int CB_PRE_LO  = 2;
  localparam int CB_IE      = 5;
  localparam int CB_PERIOD  = 6;
  localparam int CB_RUN     = 7;
  localparam logic [7:0] CTRL_RESET = 8'h20;

  // channel word indices
  localparam logic [2:0] W_LOAD  = 3'd0;
  localparam logic [2:0] W_VALUE = 3'd1;
  localparam logic [2:0] W_CTRL  = 3'd2;
  localparam logic [2:0] W_CLR   = 3'd3;
  localparam logic [2:0] W_RAW   = 3'd4;
  localparam logic [2:0] W_MASK  = 3'd5;
  localparam logic [2:0] W_BG    = 3'd6;

  typedef struct packed {
    logic ldWr;
    logic bgWr;
    logic ctlWr;
    logic clrWr;
  } chStrobe_t;

  typedef enum logic [1:0] {SEL_CH0, SEL_CH1, SEL_ID, SEL_ZERO} rdSel_e;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h04;
      3'd1: idByte = 8'h18;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtt_decode.sv
module dtt_decode
  import dtt_pkg::*;
#(
  parameter int AW = WIN_AW
) (
  input  logic                   wrEn,
  input  logic [AW-1:0]          addr,
  output chStrobe_t [NUM_CH-1:0] strobe,
  output rdSel_e                 rdSel,
  output logic [2:0]             wordIdx
);
  localparam int CH_SPAN_BITS = 6;   // 0x40 bytes for both channels
  localparam int ID_TAG_W     = AW - 5;

  logic inChan;
  logic idHit;
  logic chPick;

  assign inChan  = (addr[AW-1:CH_SPAN_BITS] == '0);
  assign idHit   = (addr[AW-1:5] == {ID_TAG_W{1'b1}});
  assign chPick  = addr[5];
  assign wordIdx = addr[4:2];

  always_comb begin
    if (inChan)     rdSel = chPick ? SEL_CH1 : SEL_CH0;
    else if (idHit) rdSel = SEL_ID;
    else            rdSel = SEL_ZERO;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strb
    logic hit;
    assign hit = wrEn && inChan && (chPick == c[0]);
    assign strobe[c].ldWr  = hit && (wordIdx == W_LOAD);
    assign strobe[c].bgWr  = hit && (wordIdx == W_BG);
    assign strobe[c].ctlWr = hit && (wordIdx == W_CTRL);
    assign strobe[c].clrWr = hit && (wordIdx == W_CLR);
  end
endmodule

// File: rtl/dtt_channel.sv
module dtt_channel
  import dtt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PRE_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  chStrobe_t     strobe,
  input  logic [DW-1:0] wrData,
  input  logic          tickEn,
  input  logic [2:0]    wordIdx,
  output logic [DW-1:0] rdWord,
  output logic          irqOut,
  output logic [DW-1:0] limitQ,
  output logic [DW-1:0] countQ,
  output logic [7:0]    ctrlQ,
  output logic          risQ
);
  localparam int NARROW_W = 16;
  localparam int DIV16_W  = 4;
  localparam logic [DW-1:0] NARROW_MAX = DW'({NARROW_W{1'b1}});

  logic [PRE_W-1:0] preCnt;
  logic             preFire;
  logic             stepEn;
  logic [DW-1:0]    reloadCur;

  function automatic logic [DW-1:0] reloadOf(input logic [7:0] ctl, input logic [DW-1:0] lim);
    if (ctl[CB_PERIOD] || ctl[CB_ONESHOT]) reloadOf = lim;
    else if (ctl[CB_WIDE])                 reloadOf = '1;
    else                                   reloadOf = NARROW_MAX;
  endfunction

  always_comb begin
    case (ctrlQ[CB_PRE_LO+1:CB_PRE_LO])
      2'b01:   preFire = (preCnt[DIV16_W-1:0] == '1);
      2'b10:   preFire = (preCnt == '1);
      default: preFire = 1'b1;
    endcase
  end

  assign stepEn    = tickEn && ctrlQ[CB_RUN] && preFire;
  assign reloadCur = reloadOf(ctrlQ, limitQ);

  always_ff @(posedge clk) begin
    if (!rstN)                          preCnt <= '0;
    else if (strobe.ctlWr)              preCnt <= '0;
    else if (tickEn && ctrlQ[CB_RUN])   preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RESET;
      limitQ <= '0;
      countQ <= '0;
    end else if (strobe.ldWr) begin
      limitQ <= wrData;
      countQ <= reloadOf(ctrlQ, wrData);
    end else if (strobe.bgWr) begin
      limitQ <= wrData;
    end else if (strobe.ctlWr) begin
      ctrlQ <= wrData[7:0];
      if (wrData[CB_RUN]) countQ <= reloadOf(wrData[7:0], limitQ);
    end else if (stepEn) begin
      if (countQ != '0)               countQ <= countQ - 1'b1;
      else if (!ctrlQ[CB_ONESHOT])    countQ <= reloadCur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                                   risQ <= 1'b0;
    else if (stepEn && !strobe.ldWr && !strobe.bgWr &&
             !strobe.ctlWr && countQ == DW'(1))                  risQ <= 1'b1;
    else if (strobe.clrWr)                                       risQ <= 1'b0;
  end

  assign irqOut = risQ && ctrlQ[CB_IE];

  always_comb begin
    case (wordIdx)
      W_LOAD, W_BG: rdWord = limitQ;
      W_VALUE:      rdWord = countQ;
      W_CTRL:       rdWord = DW'(ctrlQ);
      W_RAW:        rdWord = DW'(risQ);
      W_MASK:       rdWord = DW'(irqOut);
      default:      rdWord = '0;
    endcase
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tickEn,
  input  logic              wrEn,
  input  logic [WIN_AW-1:0] addr,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData,
  output logic              irq
);
  chStrobe_t [NUM_CH-1:0]         strobe;
  rdSel_e                         rdSel;
  logic [2:0]                     wordIdx;
  logic [NUM_CH-1:0][DW-1:0]      chRd;
  logic [NUM_CH-1:0]              chIrq;
  logic [NUM_CH-1:0][DW-1:0]      chLimit;
  logic [NUM_CH-1:0][DW-1:0]      chCount;
  logic [NUM_CH-1:0][7:0]         chCtrl;
  logic [NUM_CH-1:0]              chRis;

  dtt_decode #(.AW(WIN_AW)) u_dec (
    .wrEn(wrEn), .addr(addr), .strobe(strobe), .rdSel(rdSel), .wordIdx(wordIdx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dtt_channel #(.DW(DW), .PRE_W(PRE_W)) u_ch (
      .clk(clk), .rstN(rstN), .strobe(strobe[c]), .wrData(wrData),
      .tickEn(tickEn[c]), .wordIdx(wordIdx), .rdWord(chRd[c]),
      .irqOut(chIrq[c]), .limitQ(chLimit[c]), .countQ(chCount[c]),
      .ctrlQ(chCtrl[c]), .risQ(chRis[c])
    );
  end

  always_comb begin
    case (rdSel)
      SEL_CH0: rdData = chRd[0];
      SEL_CH1: rdData = chRd[1];
      SEL_ID:  rdData = DW'(idByte(wordIdx));
      default: rdData = '0;
    endcase
  end

  assign irq = |chIrq;
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
  import dtt_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_CH-1:0]         tickEn,
  input logic                      wrEn,
  input logic [WIN_AW-1:0]         addr,
  input logic [DW-1:0]             rdData,
  input logic                      irq,
  input logic [NUM_CH-1:0][DW-1:0] chLimit,
  input logic [NUM_CH-1:0][DW-1:0] chCount,
  input logic [NUM_CH-1:0][7:0]    chCtrl,
  input logic [NUM_CH-1:0]         chRis
);
  // R12
  outside_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[WIN_AW-1:6] != '0) |=> ($stable(chLimit) && $stable(chCtrl)));

  // R10
  id_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= 12'hFE0) |-> (rdData[DW-1:8] == '0));

  // R11
  itest_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 12'hF00 || addr == 12'hF04) |-> (rdData == '0));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(tickEn != '0 || wrEn));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chCount[c] == '0 && chCtrl[c][CB_ONESHOT] && !wrEn) |=> (chCount[c] == '0));
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!wrEn && !tickEn[c]) |=> $stable(chCount[c]));
    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 12'(c * 32 + 12) && !tickEn[c]) |=> !chRis[c]);
  end
endmodule

bind dual_tick_timer dtt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
  .rdData(rdData), .irq(irq), .chLimit(chLimit), .chCount(chCount),
  .chCtrl(chCtrl), .chRis(chRis)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  tickEn = 2'b00;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_tick_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {isWrite, req, addr, data, expected}
  localparam int NV = 32;
  localparam logic [80:0] VEC [0:NV-1] = '{
    {1'b0, 4'd1,  12'h008, 32'h0, 32'h20},        // R1
    {1'b0, 4'd1,  12'h028, 32'h0, 32'h20},        // R1
    {1'b0, 4'd1,  12'h000, 32'h0, 32'h0},         // R1
    {1'b0, 4'd1,  12'h004, 32'h0, 32'h0},         // R1
    {1'b0, 4'd1,  12'h010, 32'h0, 32'h0},         // R1
    {1'b0, 4'd1,  12'h034, 32'h0, 32'h0},         // R1
    {1'b1, 4'd3,  12'h000, 32'h11, 32'h0},        // R3
    {1'b0, 4'd3,  12'h000, 32'h0, 32'h11},        // R3
    {1'b0, 4'd6,  12'h004, 32'h0, 32'hFFFF},      // R6 free narrow reload
    {1'b0, 4'd2,  12'h020, 32'h0, 32'h0},         // R2
    {1'b1, 4'd2,  12'h020, 32'h22, 32'h0},        // R2
    {1'b0, 4'd2,  12'h020, 32'h0, 32'h22},        // R2
    {1'b0, 4'd2,  12'h000, 32'h0, 32'h11},        // R2
    {1'b1, 4'd12, 12'h040, 32'h55, 32'h0},        // R12
    {1'b1, 4'd12, 12'h060, 32'h66, 32'h0},        // R12
    {1'b1, 4'd12, 12'hFE0, 32'h77, 32'h0},        // R12
    {1'b1, 4'd12, 12'hF00, 32'h1, 32'h0},         // R12
    {1'b0, 4'd12, 12'h000, 32'h0, 32'h11},        // R12
    {1'b0, 4'd12, 12'h020, 32'h0, 32'h22},        // R12
    {1'b0, 4'd10, 12'hFE0, 32'h0, 32'h04},        // R10
    {1'b0, 4'd10, 12'hFE4, 32'h0, 32'h18},        // R10
    {1'b0, 4'd10, 12'hFE8, 32'h0, 32'h14},        // R10
    {1'b0, 4'd10, 12'hFEC, 32'h0, 32'h00},        // R10
    {1'b0, 4'd10, 12'hFF0, 32'h0, 32'h0D},        // R10
    {1'b0, 4'd10, 12'hFF4, 32'h0, 32'hF0},        // R10
    {1'b0, 4'd10, 12'hFF8, 32'h0, 32'h05},        // R10
    {1'b0, 4'd10, 12'hFFC, 32'h0, 32'hB1},        // R10
    {1'b0, 4'd11, 12'hF00, 32'h0, 32'h0},         // R11
    {1'b0, 4'd11, 12'hF04, 32'h0, 32'h0},         // R11
    {1'b0, 4'd11, 12'h040, 32'h0, 32'h0},         // R11
    {1'b0, 4'd11, 12'h01C, 32'h0, 32'h0},         // R11
    {1'b0, 4'd11, 12'h800, 32'h0, 32'h0}          // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #2;
    check(req, rdData, exp);
  endtask

  task automatic ticks(input logic [1:0] mask, input int n);
    @(negedge clk);
    tickEn = mask;
    repeat (n) @(negedge clk);
    tickEn = 2'b00;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) doWrite(VEC[i][75:64], VEC[i][63:32]);
      else readChk($sformatf("R%0d vec%0d", VEC[i][79:76], i), VEC[i][75:64], VEC[i][31:0]);
    end

    // R4 independent channels: ch1 periodic at 10
    doWrite(12'h020, 32'd10);
    doWrite(12'h028, 32'hE2);
    readChk("R13 ch1 reload", 12'h024, 32'd10);
    // R13 ch0 periodic at 3
    doWrite(12'h000, 32'd3);
    readChk("R6 free reload on load", 12'h004, 32'hFFFF);
    doWrite(12'h008, 32'hE2);
    readChk("R13 ch0 reload", 12'h004, 32'd3);
    ticks(2'b10, 4);
    readChk("R4 ch1 counted", 12'h024, 32'd6);
    readChk("R4 ch0 untouched", 12'h004, 32'd3);
    ticks(2'b01, 2);
    readChk("R4 ch0 counted", 12'h004, 32'd1);
    readChk("R4 ch1 untouched", 12'h024, 32'd6);
    readChk("R8 raw before", 12'h010, 32'd0);
    ticks(2'b01, 1);
    readChk("R8 raw set", 12'h010, 32'd1);
    readChk("R8 masked set", 12'h014, 32'd1);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    ticks(2'b01, 1);
    readChk("R6 periodic wrap", 12'h004, 32'd3);
    doWrite(12'h00C, 32'h0);
    readChk("R8 cleared", 12'h010, 32'd0);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    // R5 prescale
    doWrite(12'h000, 32'd5);
    doWrite(12'h008, 32'hE6);
    ticks(2'b01, 15);
    readChk("R5 div16 hold", 12'h004, 32'd5);
    ticks(2'b01, 1);
    readChk("R5 div16 step", 12'h004, 32'd4);
    doWrite(12'h008, 32'hEA);
    ticks(2'b01, 255);
    readChk("R5 div256 hold", 12'h004, 32'd5);
    ticks(2'b01, 1);
    readChk("R5 div256 step", 12'h004, 32'd4);
    doWrite(12'h008, 32'hEE);
    ticks(2'b01, 1);
    readChk("R5 code11 as div1", 12'h004, 32'd4);

    // R3 background load, R11 value write ignored
    doWrite(12'h018, 32'd9);
    readChk("R3 bg limit", 12'h000, 32'd9);
    readChk("R3 bg count kept", 12'h004, 32'd4);
    doWrite(12'h004, 32'h1234);
    readChk("R11 value write ignored", 12'h004, 32'd4);

    // R7 one-shot
    doWrite(12'h000, 32'd2);
    doWrite(12'h008, 32'hA3);
    ticks(2'b01, 2);
    readChk("R7 reached zero", 12'h004, 32'd0);
    readChk("R8 oneshot raw", 12'h010, 32'd1);
    ticks(2'b01, 3);
    readChk("R7 holds zero", 12'h004, 32'd0);
    doWrite(12'h00C, 32'h0);

    // R8 masking with interrupt enable off
    doWrite(12'h000, 32'd1);
    doWrite(12'h008, 32'h83);
    ticks(2'b01, 1);
    readChk("R8 raw no IE", 12'h010, 32'd1);
    readChk("R8 masked no IE", 12'h014, 32'd0);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    doWrite(12'h00C, 32'h0);

    // R8 set wins over same-cycle clear
    doWrite(12'h000, 32'd1);
    doWrite(12'h008, 32'hE2);
    @(negedge clk);
    wrEn = 1'b1; addr = 12'h00C; tickEn = 2'b01;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 2'b00;
    readChk("R8 set wins", 12'h010, 32'd1);
    doWrite(12'h00C, 32'h0);

    // R6 free-running reload values
    doWrite(12'h008, 32'hA0);
    readChk("R6 free narrow", 12'h004, 32'h0000FFFF);
    ticks(2'b01, 1);
    readChk("R6 free narrow step", 12'h004, 32'h0000FFFE);
    doWrite(12'h008, 32'hA2);
    readChk("R6 free wide", 12'h004, 32'hFFFFFFFF);
    readChk("R2 ch1 ctrl", 12'h028, 32'hE2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule